// File: doc/BRIEF.md
# CAN Receive Acceptance Filter with Frame Queue

This block takes the header of a CAN frame that has already been deserialized (the identifier, the IDE and RTR flags and the payload) and decides whether to keep it. It compares the header against a programmable filter table. If a filter element accepts the frame, the frame is written into a six-entry receive queue together with the index of the element that matched. Software or a downstream engine drains the queue one entry at a time with a pop strobe. Status flags report a non-empty queue, a nearly full queue and a dropped frame.

The filter table is eight 32-bit value words plus eight 32-bit mask words. A format selector decides how these words are read:
- as eight extended elements of one word each;
- as sixteen standard elements of one half-word each;
- as thirty-two partial elements of one byte each.

In every format, a mask bit at 0 removes the matching value bit from the comparison. A small controller handles each header in three steps: IDLE takes the header, MATCH registers the filter result, and STORE writes the queue. It signals on `hdr_ready` when it can take the next header.

Top module: `rx_accept_top`

## Requirements
- R1: After reset, `rd_avail`, `fifo_warn` and `fifo_ovf` are 0 and `hdr_ready` is 1. Every table value and mask word resets to zero, so until the table is written every frame matches element 0.
- R2: With `fmt_sel`=0 (extended), word w is element w. Its bit 31 compares RTR, bit 30 compares IDE and bits 28:0 compare `frm_id[28:0]`. Bit 29 is never compared.
- R3: With `fmt_sel`=1 (standard), word w holds element 2w in bits 31:16 and element 2w+1 in bits 15:0. Within a half-word, bit 15 compares RTR, bit 14 compares IDE and bits 10:0 compare `frm_id[10:0]`. Bits 13:11 are never compared.
- R4: With `fmt_sel`=2 (partial), word w holds element 4w+k in bits 31-8k down to 24-8k. The element compares `frm_id[28:21]` for an extended frame (IDE=1) and `frm_id[10:3]` for a standard frame. RTR is not compared.
- R5: A mask bit of 0 makes the matching value bit a don't-care. A mask bit of 1 requires equality.
- R6: When several elements match, the lowest index wins, and that index appears on `rd_hit_idx` when the frame reaches the head of the queue.
- R7: A frame that no element matches is discarded. With `fmt_sel`=3, no element matches.
- R8: A header is taken on a clock edge where `frm_valid` and `hdr_ready` are both 1. `hdr_ready` is then 0 for exactly two cycles. The queue update is visible when `hdr_ready` returns to 1.
- R9: The queue holds up to six frames in arrival order. A pop strobe while `rd_avail` is 1 removes the head entry.
- R10: A matched frame that arrives while six entries are held is dropped and sets the sticky `fifo_ovf`. Only `ovf_clr` clears `fifo_ovf`.
- R11: `fifo_warn` is 1 exactly while the queue holds five or more entries.
- R12: `rd_avail` is 1 exactly while the queue holds at least one entry, and the `rd_*` outputs then show the oldest entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fmt_sel | input | 2 | Table format: 0 extended, 1 standard, 2 partial, 3 none |
| tbl_we | input | 1 | Table word write strobe |
| tbl_is_mask | input | 1 | 1 writes the mask word, 0 the value word |
| tbl_addr | input | 3 | Table word index |
| tbl_wdata | input | 32 | Table word data |
| frm_valid | input | 1 | Header present |
| frm_id | input | 29 | Identifier; standard IDs in bits 10:0 |
| frm_ide | input | 1 | Extended frame flag |
| frm_rtr | input | 1 | Remote frame flag |
| frm_data | input | 64 | Frame payload |
| hdr_ready | output | 1 | Controller idle, header can be taken |
| rd_pop | input | 1 | Remove head entry |
| ovf_clr | input | 1 | Clear overflow flag |
| rd_avail | output | 1 | Queue not empty |
| rd_id | output | 29 | Head identifier |
| rd_ide | output | 1 | Head IDE flag |
| rd_rtr | output | 1 | Head RTR flag |
| rd_data | output | 64 | Head payload |
| rd_hit_idx | output | 5 | Index of the filter element that accepted the head |
| fifo_warn | output | 1 | Five or more entries held |
| fifo_ovf | output | 1 | Sticky: a matched frame was dropped |

## Verification
The hardest case to reach from the ports is a matched frame arriving at a full queue, with another element also matching at a higher index. This exercises the drop, the sticky flag and the priority rule together. A directed sequence programs two overlapping elements and sends seven matching frames without popping. It then checks that the warning appears at five entries, that the seventh frame leaves the queue contents unchanged, and that the stored index is the lower one. Random rounds use sparse masks, so matches are frequent and the queue fills and drains repeatedly in all three formats.

// File: rtl/rx_accept_pkg.sv
package rx_accept_pkg;
    localparam int ID_W      = 29;
    localparam int DATA_W    = 64;
    localparam int TBL_WORDS = 8;
    localparam int MAX_ELEMS = 4 * TBL_WORDS;
    localparam int HIT_W     = $clog2(MAX_ELEMS);
    localparam int ADDR_W    = $clog2(TBL_WORDS);

    typedef enum logic [1:0] {
        FMT_EXT  = 2'd0,
        FMT_STD  = 2'd1,
        FMT_PART = 2'd2,
        FMT_NONE = 2'd3
    } fmt_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_MATCH = 2'd1,
        ST_STORE = 2'd2
    } ctl_state_e;

    typedef struct packed {
        logic [ID_W-1:0]   id;
        logic              ide;
        logic              rtr;
        logic [DATA_W-1:0] data;
        logic [HIT_W-1:0]  hit;
    } rx_entry_t;
endpackage

// File: rtl/rx_filter_table.sv
module rx_filter_table
    import rx_accept_pkg::*;
#(
    parameter int WORDS = TBL_WORDS,
    localparam int AW   = $clog2(WORDS)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        we,
    input  logic                        is_mask,
    input  logic [AW-1:0]               addr,
    input  logic [31:0]                 wdata,
    output logic [WORDS-1:0][31:0]      val_words,
    output logic [WORDS-1:0][31:0]      msk_words
);
    for (genvar w = 0; w < WORDS; w++) begin : g_word
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                val_words[w] <= '0;
                msk_words[w] <= '0;
            end else if (we && addr == AW'(w)) begin
                if (is_mask) msk_words[w] <= wdata;
                else         val_words[w] <= wdata;
            end
        end
    end
endmodule

// File: rtl/rx_lowest_pick.sv
module rx_lowest_pick #(
    parameter int N = 32,
    localparam int W = $clog2(N)
) (
    input  logic [N-1:0] req,
    output logic         found,
    output logic [W-1:0] idx
);
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = W'(i);
        end
    end
    assign found = |req;
endmodule

// File: rtl/rx_id_matcher.sv
module rx_id_matcher
    import rx_accept_pkg::*;
#(
    parameter int WORDS = TBL_WORDS,
    localparam int NE   = 4 * WORDS,
    localparam int IW   = $clog2(NE)
) (
    input  logic [1:0]              fmt,
    input  logic [WORDS-1:0][31:0]  val_words,
    input  logic [WORDS-1:0][31:0]  msk_words,
    input  logic [ID_W-1:0]         id,
    input  logic                    ide,
    input  logic                    rtr,
    output logic                    hit,
    output logic [IW-1:0]           hit_idx
);
    localparam logic [31:0] EXT_CARE = 32'hDFFF_FFFF;
    localparam logic [15:0] STD_CARE = 16'hC7FF;

    logic [31:0]      ext_key;
    logic [15:0]      std_key;
    logic [7:0]       part_key;
    logic [WORDS-1:0]   ext_hit;
    logic [2*WORDS-1:0] std_hit;
    logic [NE-1:0]      part_hit;
    logic [NE-1:0]      req;

    assign ext_key  = {rtr, ide, 1'b0, id};
    assign std_key  = {rtr, ide, 3'b000, id[10:0]};
    assign part_key = ide ? id[28:21] : id[10:3];

    for (genvar w = 0; w < WORDS; w++) begin : g_word
        assign ext_hit[w] = ((val_words[w] ^ ext_key) & msk_words[w] & EXT_CARE) == '0;
        for (genvar h = 0; h < 2; h++) begin : g_half
            assign std_hit[2*w+h] =
                ((val_words[w][31-16*h -: 16] ^ std_key) &
                 msk_words[w][31-16*h -: 16] & STD_CARE) == '0;
        end
        for (genvar k = 0; k < 4; k++) begin : g_byte
            assign part_hit[4*w+k] =
                ((val_words[w][31-8*k -: 8] ^ part_key) &
                 msk_words[w][31-8*k -: 8]) == '0;
        end
    end

    always_comb begin
        unique case (fmt_e'(fmt))
            FMT_EXT:  req = NE'(ext_hit);
            FMT_STD:  req = NE'(std_hit);
            FMT_PART: req = part_hit;
            FMT_NONE: req = '0;
        endcase
    end

    rx_lowest_pick #(.N(NE)) u_pick (
        .req   (req),
        .found (hit),
        .idx   (hit_idx)
    );
endmodule

// File: rtl/rx_accept_ctrl.sv
module rx_accept_ctrl
    import rx_accept_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frm_valid,
    input  logic [ID_W-1:0]   frm_id,
    input  logic              frm_ide,
    input  logic              frm_rtr,
    input  logic [DATA_W-1:0] frm_data,
    input  logic              m_hit,
    input  logic [HIT_W-1:0]  m_idx,
    output logic [ID_W-1:0]   hdr_id,
    output logic              hdr_ide,
    output logic              hdr_rtr,
    output logic              ready,
    output logic              push,
    output rx_entry_t         push_entry
);
    ctl_state_e state_q, state_d;
    logic              take_hdr, take_hit;
    logic [DATA_W-1:0] data_q;
    logic              hit_q;
    logic [HIT_W-1:0]  idx_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d  = state_q;
        ready    = 1'b0;
        take_hdr = 1'b0;
        take_hit = 1'b0;
        push     = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                ready = 1'b1;
                if (frm_valid) begin
                    take_hdr = 1'b1;
                    state_d  = ST_MATCH;
                end
            end
            ST_MATCH: begin
                take_hit = 1'b1;
                state_d  = ST_STORE;
            end
            ST_STORE: begin
                push    = hit_q;
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hdr_id  <= '0;
            hdr_ide <= 1'b0;
            hdr_rtr <= 1'b0;
            data_q  <= '0;
            hit_q   <= 1'b0;
            idx_q   <= '0;
        end else begin
            if (take_hdr) begin
                hdr_id  <= frm_id;
                hdr_ide <= frm_ide;
                hdr_rtr <= frm_rtr;
                data_q  <= frm_data;
            end
            if (take_hit) begin
                hit_q <= m_hit;
                idx_q <= m_idx;
            end
        end
    end

    assign push_entry = '{id: hdr_id, ide: hdr_ide, rtr: hdr_rtr,
                          data: data_q, hit: idx_q};
endmodule

// File: rtl/rx_frame_fifo.sv
module rx_frame_fifo
    import rx_accept_pkg::*;
#(
    parameter int DEPTH = 6,
    parameter int WARN  = 5,
    localparam int PW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       push,
    input  rx_entry_t  push_entry,
    input  logic       pop,
    input  logic       ovf_clr,
    output rx_entry_t  head,
    output logic       avail,
    output logic       warn,
    output logic       ovf,
    output logic [CW-1:0] fill
);
    rx_entry_t         mem [DEPTH];
    logic [PW-1:0]     wr_ptr, rd_ptr;
    logic [CW-1:0]     cnt_d;
    logic              do_push, do_pop;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign do_pop  = pop && fill != '0;
    assign do_push = push && fill != CW'(DEPTH);

    always_comb begin
        cnt_d = fill;
        if (do_push && !do_pop) cnt_d = fill + 1'b1;
        if (do_pop && !do_push) cnt_d = fill - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            fill   <= '0;
            warn   <= 1'b0;
            ovf    <= 1'b0;
        end else begin
            if (do_push) wr_ptr <= bump(wr_ptr);
            if (do_pop)  rd_ptr <= bump(rd_ptr);
            fill <= cnt_d;
            warn <= cnt_d >= CW'(WARN);
            if (push && !do_push) ovf <= 1'b1;
            else if (ovf_clr)     ovf <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= push_entry;
    end

    assign head  = mem[rd_ptr];
    assign avail = fill != '0;
endmodule

// File: rtl/rx_accept_top.sv
module rx_accept_top
    import rx_accept_pkg::*;
#(
    parameter int DEPTH = 6,
    parameter int WARN  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        fmt_sel,
    input  logic              tbl_we,
    input  logic              tbl_is_mask,
    input  logic [ADDR_W-1:0] tbl_addr,
    input  logic [31:0]       tbl_wdata,
    input  logic              frm_valid,
    input  logic [ID_W-1:0]   frm_id,
    input  logic              frm_ide,
    input  logic              frm_rtr,
    input  logic [DATA_W-1:0] frm_data,
    output logic              hdr_ready,
    input  logic              rd_pop,
    input  logic              ovf_clr,
    output logic              rd_avail,
    output logic [ID_W-1:0]   rd_id,
    output logic              rd_ide,
    output logic              rd_rtr,
    output logic [DATA_W-1:0] rd_data,
    output logic [HIT_W-1:0]  rd_hit_idx,
    output logic              fifo_warn,
    output logic              fifo_ovf
);
    localparam int CW = $clog2(DEPTH + 1);

    logic [TBL_WORDS-1:0][31:0] val_words, msk_words;
    logic [ID_W-1:0]  hdr_id;
    logic             hdr_ide, hdr_rtr;
    logic             m_hit, push;
    logic [HIT_W-1:0] m_idx;
    rx_entry_t        push_entry, head;
    logic [CW-1:0]    fill_lvl;

    rx_filter_table #(.WORDS(TBL_WORDS)) u_table (
        .clk(clk), .rst_n(rst_n), .we(tbl_we), .is_mask(tbl_is_mask),
        .addr(tbl_addr), .wdata(tbl_wdata),
        .val_words(val_words), .msk_words(msk_words)
    );

    rx_id_matcher #(.WORDS(TBL_WORDS)) u_match (
        .fmt(fmt_sel), .val_words(val_words), .msk_words(msk_words),
        .id(hdr_id), .ide(hdr_ide), .rtr(hdr_rtr),
        .hit(m_hit), .hit_idx(m_idx)
    );

    rx_accept_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .frm_valid(frm_valid), .frm_id(frm_id),
        .frm_ide(frm_ide), .frm_rtr(frm_rtr), .frm_data(frm_data),
        .m_hit(m_hit), .m_idx(m_idx),
        .hdr_id(hdr_id), .hdr_ide(hdr_ide), .hdr_rtr(hdr_rtr),
        .ready(hdr_ready), .push(push), .push_entry(push_entry)
    );

    rx_frame_fifo #(.DEPTH(DEPTH), .WARN(WARN)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push(push), .push_entry(push_entry),
        .pop(rd_pop), .ovf_clr(ovf_clr), .head(head), .avail(rd_avail),
        .warn(fifo_warn), .ovf(fifo_ovf), .fill(fill_lvl)
    );

    assign rd_id      = head.id;
    assign rd_ide     = head.ide;
    assign rd_rtr     = head.rtr;
    assign rd_data    = head.data;
    assign rd_hit_idx = head.hit;
endmodule

// File: rtl/rx_accept_chk.sv
module rx_accept_chk #(
    parameter int DEPTH = 6,
    parameter int WARN  = 5,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          frm_valid,
    input logic          hdr_ready,
    input logic          rd_pop,
    input logic          rd_avail,
    input logic          ovf_clr,
    input logic          fifo_warn,
    input logic          fifo_ovf,
    input logic [CW-1:0] fill
);
    a_r8_busy_after_take: assert property (@(posedge clk) disable iff (!rst_n)
        frm_valid && hdr_ready |=> !hdr_ready);

    a_r8_busy_two_cycles: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hdr_ready) |=> !hdr_ready);

    a_r8_back_to_ready: assert property (@(posedge clk) disable iff (!rst_n)
        !hdr_ready && !$fell(hdr_ready) |=> hdr_ready);

    a_r9_fill_bound: assert property (@(posedge clk) disable iff (!rst_n)
        fill <= CW'(DEPTH));

    a_r9_pop_removes: assert property (@(posedge clk) disable iff (!rst_n)
        rd_pop && rd_avail && hdr_ready |=> fill == $past(fill) - 1'b1);

    a_r10_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_ovf && !ovf_clr |=> fifo_ovf);

    a_r10_ovf_only_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fifo_ovf) |-> $past(fill) == CW'(DEPTH));

    a_r11_warn_level: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_warn == (fill >= CW'(WARN)));

    a_r12_avail_level: assert property (@(posedge clk) disable iff (!rst_n)
        rd_avail |-> fill != '0);
endmodule

bind rx_accept_top rx_accept_chk #(.DEPTH(DEPTH), .WARN(WARN)) u_chk (
    .clk(clk), .rst_n(rst_n), .frm_valid(frm_valid), .hdr_ready(hdr_ready),
    .rd_pop(rd_pop), .rd_avail(rd_avail), .ovf_clr(ovf_clr),
    .fifo_warn(fifo_warn), .fifo_ovf(fifo_ovf), .fill(fill_lvl)
);

// File: tb/rx_accept_top_bench.sv
module rx_accept_top_bench;
    import rx_accept_pkg::*;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0] fmt_sel = 2'd0;
    logic tbl_we = 0, tbl_is_mask = 0;
    logic [2:0] tbl_addr = 0;
    logic [31:0] tbl_wdata = 0;
    logic frm_valid = 0, frm_ide = 0, frm_rtr = 0;
    logic [28:0] frm_id = 0;
    logic [63:0] frm_data = 0;
    logic hdr_ready, rd_pop = 0, ovf_clr = 0;
    logic rd_avail, rd_ide, rd_rtr, fifo_warn, fifo_ovf;
    logic [28:0] rd_id;
    logic [63:0] rd_data;
    logic [4:0] rd_hit_idx;

    int checks = 0, fails = 0;
    logic [31:0] tv [8];
    logic [31:0] tm [8];
    rx_entry_t q[$];
    logic m_ovf = 0;

    always #2 clk = ~clk;

    rx_accept_top u_rx_accept_top (.*);

    task automatic check(string tag, logic [127:0] act, logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic void ref_match(input logic [1:0] f, input logic [28:0] id,
                                      input logic ide, input logic rtr,
                                      output logic hit, output logic [4:0] idx);
        hit = 0; idx = 0;
        for (int e = 31; e >= 0; e--) begin
            logic ok; logic [31:0] v, m, k;
            ok = 0;
            if (f == 2'd0 && e < 8) begin
                v = tv[e]; m = tm[e] & 32'hDFFF_FFFF; k = {rtr, ide, 1'b0, id};
                ok = ((v ^ k) & m) == 0;
            end else if (f == 2'd1 && e < 16) begin
                v = {16'd0, tv[e/2] >> (16 * (1 - e % 2))} & 32'hFFFF;
                m = {16'd0, tm[e/2] >> (16 * (1 - e % 2))} & 32'hC7FF;
                k = {16'd0, rtr, ide, 3'b0, id[10:0]};
                ok = ((v ^ k) & m) == 0;
            end else if (f == 2'd2) begin
                v = (tv[e/4] >> (8 * (3 - e % 4))) & 32'hFF;
                m = (tm[e/4] >> (8 * (3 - e % 4))) & 32'hFF;
                k = {24'd0, ide ? id[28:21] : id[10:3]};
                ok = ((v ^ k) & m) == 0;
            end
            if (ok) begin hit = 1; idx = 5'(e); end
        end
    endfunction

    task automatic wr_word(int a, logic mask, logic [31:0] d);
        @(negedge clk);
        tbl_we = 1; tbl_is_mask = mask; tbl_addr = 3'(a); tbl_wdata = d;
        if (mask) tm[a] = d; else tv[a] = d;
        @(negedge clk);
        tbl_we = 0;
    endtask

    task automatic fill_all(logic [31:0] v, logic [31:0] m);
        for (int a = 0; a < 8; a++) begin
            wr_word(a, 0, v);
            wr_word(a, 1, m);
        end
    endtask

    task automatic send(logic [28:0] id, logic ide, logic rtr);
        logic hit; logic [4:0] idx; rx_entry_t e;
        @(negedge clk);
        while (!hdr_ready) @(negedge clk);
        frm_valid = 1; frm_id = id; frm_ide = ide; frm_rtr = rtr;
        frm_data = {$urandom, $urandom};
        ref_match(fmt_sel, id, ide, rtr, hit, idx);
        e = '{id: id, ide: ide, rtr: rtr, data: frm_data, hit: idx};
        @(negedge clk);
        frm_valid = 0;
        check("R8 busy after header", 128'(hdr_ready), 128'(0));
        @(negedge clk);
        check("R8 busy second cycle", 128'(hdr_ready), 128'(0));
        @(negedge clk);
        check("R8 ready again", 128'(hdr_ready), 128'(1));
        if (hit) begin
            if (q.size() == 6) m_ovf = 1;
            else q.push_back(e);
        end
    endtask

    task automatic pop_one();
        @(negedge clk);
        rd_pop = 1;
        @(negedge clk);
        rd_pop = 0;
        if (q.size() != 0) void'(q.pop_front());
    endtask

    task automatic clr_ovf();
        @(negedge clk);
        ovf_clr = 1;
        @(negedge clk);
        ovf_clr = 0;
        m_ovf = 0;
    endtask

    task automatic verify(string tag);
        check({tag, " R12 avail"}, 128'(rd_avail), 128'(q.size() != 0));
        check({tag, " R11 warn"}, 128'(fifo_warn), 128'(q.size() >= 5));
        check({tag, " R10 ovf"}, 128'(fifo_ovf), 128'(m_ovf));
        if (q.size() != 0) begin
            check({tag, " R9 R6 head"},
                  128'({rd_id, rd_ide, rd_rtr, rd_data, rd_hit_idx}), 128'(q[0]));
        end
    endtask

    task automatic drain();
        while (q.size() != 0) pop_one();
        verify("drain");
    endtask

    initial begin
        for (int a = 0; a < 8; a++) begin tv[a] = 0; tm[a] = 0; end
        repeat (3) @(negedge clk);
        check("R1 ready", 128'(hdr_ready), 128'(1));
        check("R1 avail", 128'(rd_avail), 128'(0));
        check("R1 warn/ovf", 128'({fifo_warn, fifo_ovf}), 128'(0));
        rst_n = 1;
        // R1: zero table matches element 0
        send(29'h1234567, 1, 1);
        verify("R1 reset table");
        check("R1 idx0", 128'(rd_hit_idx), 128'(0));
        drain();

        // R2 extended
        fmt_sel = 2'd0;
        fill_all(32'hFFFF_FFFF, 32'hFFFF_FFFF);
        wr_word(3, 0, {1'b0, 1'b1, 1'b1, 29'h0ABC_DE12});
        send(29'h0ABC_DE12, 1, 0);
        verify("R2 ext exact");
        check("R2 idx3", 128'(rd_hit_idx), 128'(3));
        send(29'h0ABC_DE12, 1, 1);
        send(29'h0ABC_DE12, 0, 0);
        verify("R2 R7 ide/rtr mismatch");
        drain();

        // R5 mask don't-care
        wr_word(3, 1, 32'hFFFF_FF00);
        send(29'h0ABC_DE99, 1, 0);
        verify("R5 masked low byte");
        check("R5 idx", 128'(rd_hit_idx), 128'(3));
        drain();

        // R3 standard
        fmt_sel = 2'd1;
        fill_all(32'hFFFF_FFFF, 32'hFFFF_FFFF);
        wr_word(5, 0, {16'hFFFF, 1'b1, 1'b0, 3'b111, 11'h5A3});
        send(29'h1FFF_F5A3, 0, 1);
        verify("R3 std low half");
        check("R3 idx11", 128'(rd_hit_idx), 128'(11));
        send(29'h05A3, 1, 1);
        verify("R3 ext frame rejected");
        drain();

        // R4 partial and R6 priority
        fmt_sel = 2'd2;
        fill_all(32'hFFFF_FFFF, 32'hFFFF_FFFF);
        wr_word(6, 0, 32'hFF3C_FFFF);
        wr_word(2, 0, 32'hFFFF_FF3C);
        send({8'h3C, 21'h0}, 1, 1);
        verify("R4 R6 partial ext");
        check("R6 lowest idx", 128'(rd_hit_idx), 128'(11));
        send({18'h0, 8'h3C, 3'b101}, 0, 0);
        verify("R4 partial std");
        drain();

        // R7 no format
        fmt_sel = 2'd3;
        fill_all(32'h0, 32'h0);
        send(29'h0, 0, 0);
        verify("R7 fmt none");

        // R10/R11 fill to overflow with overlapping elements
        fmt_sel = 2'd0;
        wr_word(1, 1, 32'h0);
        for (int i = 0; i < 7; i++) begin
            send(29'(i * 77), i % 2, 0);
            verify("R11 R10 fill");
        end
        check("R10 dropped ovf", 128'(fifo_ovf), 128'(1));
        pop_one();
        verify("R11 warn holds at5");
        pop_one();
        verify("R11 warn clear at4");
        check("R10 sticky", 128'(fifo_ovf), 128'(1));
        clr_ovf();
        verify("R10 cleared");
        drain();

        // random rounds
        for (int r = 0; r < 600; r++) begin
            int op;
            op = $urandom_range(0, 9);
            if (op == 0) begin
                fmt_sel = 2'($urandom_range(0, 3));
                for (int a = 0; a < 8; a++) begin
                    wr_word(a, 0, $urandom);
                    wr_word(a, 1, $urandom & $urandom & $urandom);
                end
            end else if (op < 6) begin
                send(29'($urandom), 1'($urandom), 1'($urandom));
            end else if (op < 9) begin
                pop_one();
            end else if (m_ovf) begin
                clr_ovf();
            end
            verify("random");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd1357));
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule